// File: doc/BRIEF.md
# Reset Cause and Startup Sequencer

This block merges three reset sources into a single core reset and remembers which one fired. The power-good input acts as the power-on source. A watchdog request is taken only while the core runs. A USB bus-reset detect never resets the core: it only clears the USB device address and marks its own status flag. Firmware reads a byte-wide status image. It clears a flag by writing 0 to that flag's bit position.

After power comes up, the sequencer reads a strap input and the USB line states. It then either parks in a suspend wait or starts a start-up delay. The delay has two lengths. The short one is used whenever the strap is high. With the strap low, the long one is used while the power-on flag is still set, and the short one once firmware has cleared that flag. The delay counts an external microsecond tick. A scale parameter shortens both lengths for simulation.

The state machine has four states. `ST_PWRUP` is the single decision cycle after power-good rises. `ST_SUSP` is the suspend wait. `ST_HOLD` is the start-up delay. `ST_RUN` is the core running. Its transitions are:
- `ST_PWRUP` to `ST_SUSP` when the strap is high and the lines are idle.
- `ST_PWRUP` to `ST_HOLD` otherwise.
- `ST_SUSP` to `ST_HOLD` on a wake condition.
- `ST_HOLD` to `ST_RUN` when the count completes.
- `ST_RUN` to `ST_HOLD` on an accepted watchdog request.
- Any state to `ST_PWRUP` while power-good is low.

Top module: `rst_cause_seq`

## Requirements
- R1: While pwr_good is low, core_rst=1, usb_addr_clr=1, suspended=0 and status=8'h10 (bit 4 is the power-on flag; bit 5 is the USB bus-reset flag; bit 6 is the watchdog flag; all other bits read 0).
- R2: On the first clock after pwr_good rises, the state depends on the strap and the lines. If strap=1 and the lines are idle (usb_dm=1, usb_dp=0), the block enters suspend: suspended=1 and core_rst=1. While suspended, ticks have no effect.
- R3: Suspend ends on K (usb_dp=1, usb_dm=0), on SE0 (both 0) or on usb_bus_rst=1. The SE1 state (both 1) does not wake it. On wake, a start-up delay begins.
- R4: The delay length is sampled when the delay starts. It is SHORT_US/SCALE ticks if strap=1. With strap=0, it is LONG_US/SCALE ticks if status bit 4 is set, and SHORT_US/SCALE ticks if bit 4 is clear.
- R5: core_rst stays 1 throughout the delay. It falls one clock after the clock that consumes the final tick. Without tick pulses, the delay makes no progress.
- R6: usb_wdt_req... see R6 text: a wdt_req pulse while the core runs sets status bit 6, raises core_rst on the next clock and starts a fresh delay.
- R7: wdt_req while core_rst=1 is ignored. Bit 6 is not set and the running delay is not restarted.
- R8: usb_bus_rst=1 drives usb_addr_clr=1 in the same cycle and sets status bit 5. It leaves core_rst unchanged.
- R9: A register write clears each of bits 4..6 whose written bit is 0 and keeps each whose written bit is 1. A write never sets a flag.
- R10: A set event and a clearing write to the same flag in the same cycle leave the flag set.
- R11: usb_addr_clr=1 in every cycle in which core_rst=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_good | input | 1 | Supply above trip level; low acts as asynchronous power-on reset |
| tick_us | input | 1 | One-cycle pulse per microsecond; advances the delay |
| strap | input | 1 | Start-up mode strap |
| usb_dm | input | 1 | USB D- line state |
| usb_dp | input | 1 | USB D+ line state |
| usb_bus_rst | input | 1 | USB bus reset detected |
| wdt_req | input | 1 | Watchdog reset request |
| reg_we | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| core_rst | output | 1 | Core reset, active high |
| usb_addr_clr | output | 1 | Clear the USB device address |
| suspended | output | 1 | Suspend wait active |
| status | output | 8 | Reset cause flags (bits 4, 5, 6) |

## Verification
The hardest situation to reach is a delay whose length depends on a flag that only firmware can change. The stimulus reaches it in two steps. It first releases the core after a full long delay that follows power-on, then clears the power-on flag through the write port, and only then issues a watchdog request. The short length that results shows that the length was sampled at the moment the delay started. The suspend path is reached by power-cycling with the strap high and idle lines. The bench holds SE1 to show that this state does not wake the block, then drives K or SE0 to wake it.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    typedef enum logic [1:0] {
        ST_PWRUP = 2'd0,
        ST_SUSP  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_RUN   = 2'd3
    } rcs_state_t;

    localparam int unsigned FLAG_POR = 4;
    localparam int unsigned FLAG_USB = 5;
    localparam int unsigned FLAG_WDR = 6;
endpackage

// File: rtl/rcs_status.sv
module rcs_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_usb,
    input  logic       set_wdr,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] status
);
    import rcs_pkg::*;

    logic f_por, f_usb, f_wdr;
    logic keep_por, keep_usb, keep_wdr;

    always_comb begin
        keep_por = we ? wdata[FLAG_POR] : 1'b1;
        keep_usb = we ? wdata[FLAG_USB] : 1'b1;
        keep_wdr = we ? wdata[FLAG_WDR] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_por <= 1'b1;
            f_usb <= 1'b0;
            f_wdr <= 1'b0;
        end else begin
            f_por <= f_por & keep_por;
            f_usb <= set_usb | (f_usb & keep_usb);
            f_wdr <= set_wdr | (f_wdr & keep_wdr);
        end
    end

    always_comb begin
        status           = 8'h00;
        status[FLAG_POR] = f_por;
        status[FLAG_USB] = f_usb;
        status[FLAG_WDR] = f_wdr;
    end

    // R10: an event in a cycle always shows as a set flag afterwards
    a_r10_usb_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_usb |=> status[FLAG_USB]);
    a_r10_wdr_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_wdr |=> status[FLAG_WDR]);
    // R9: a flag never rises without its event
    a_r9_no_spurious_usb: assert property (@(posedge clk) disable iff (!rst_n)
        !set_usb |=> !$rose(status[FLAG_USB]));
    a_r9_por_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(status[FLAG_POR]));
endmodule

// File: rtl/rcs_delay.sv
module rcs_delay #(
    parameter int unsigned SHORT_TICKS = 128,
    parameter int unsigned LONG_TICKS  = 96000,
    localparam int unsigned CW = $clog2(LONG_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    input  logic tick,
    output logic done
);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_TICKS);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= long_sel ? LONG_V : SHORT_V;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R5: the count only moves down, and only on a tick, between loads
    a_r5_no_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> cnt <= $past(cnt));
    a_r5_tick_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !tick) |=> $stable(cnt));
endmodule

// File: rtl/rcs_seq.sv
module rcs_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    input  logic usb_dm,
    input  logic usb_dp,
    input  logic usb_bus_rst,
    input  logic wdt_req,
    input  logic dly_done,
    output logic dly_start,
    output logic wdt_take,
    output logic core_rst,
    output logic suspended
);
    import rcs_pkg::*;

    rcs_state_t state, nxt;
    logic lines_idle, wake;

    assign lines_idle = usb_dm & ~usb_dp;
    assign wake       = usb_bus_rst | ~usb_dm;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_PWRUP: nxt = (strap && lines_idle) ? ST_SUSP : ST_HOLD;
            ST_SUSP:  if (wake) nxt = ST_HOLD;
            ST_HOLD:  if (dly_done) nxt = ST_RUN;
            ST_RUN:   if (wdt_req) nxt = ST_HOLD;
            default:  nxt = ST_PWRUP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= nxt;
    end

    always_comb begin
        core_rst  = 1'b1;
        suspended = 1'b0;
        dly_start = 1'b0;
        wdt_take  = 1'b0;
        unique case (state)
            ST_PWRUP: dly_start = (nxt == ST_HOLD);
            ST_SUSP: begin
                suspended = 1'b1;
                dly_start = wake;
            end
            ST_HOLD: ;
            ST_RUN: begin
                core_rst  = 1'b0;
                wdt_take  = wdt_req;
                dly_start = wdt_req;
            end
            default: ;
        endcase
    end

    // R2: suspend keeps the core in reset
    a_r2_susp_holds_core: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> core_rst);
    // R5: release only after the counter reached its terminal count
    a_r5_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_rst) |-> $past(dly_done));
    // R6: accepted watchdog request reasserts reset next cycle
    a_r6_wdt_resets: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_take |=> core_rst);
    // R3: leaving suspend never lands directly in run
    a_r3_susp_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(suspended) |-> core_rst);
endmodule

// File: rtl/rst_cause_seq.sv
module rst_cause_seq #(
    parameter int unsigned SHORT_US = 128,
    parameter int unsigned LONG_US  = 96000,
    parameter int unsigned SCALE    = 1
) (
    input  logic       clk,
    input  logic       pwr_good,
    input  logic       tick_us,
    input  logic       strap,
    input  logic       usb_dm,
    input  logic       usb_dp,
    input  logic       usb_bus_rst,
    input  logic       wdt_req,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic       core_rst,
    output logic       usb_addr_clr,
    output logic       suspended,
    output logic [7:0] status
);
    import rcs_pkg::*;

    localparam int unsigned SHORT_T = (SHORT_US / SCALE) > 0 ? SHORT_US / SCALE : 1;
    localparam int unsigned LONG_T  = (LONG_US / SCALE) > 0 ? LONG_US / SCALE : 1;

    logic dly_start, dly_done, dly_long, wdt_take;

    assign dly_long     = ~strap & status[FLAG_POR];
    assign usb_addr_clr = core_rst | usb_bus_rst;

    rcs_seq u_seq (
        .clk        (clk),
        .rst_n      (pwr_good),
        .strap      (strap),
        .usb_dm     (usb_dm),
        .usb_dp     (usb_dp),
        .usb_bus_rst(usb_bus_rst),
        .wdt_req    (wdt_req),
        .dly_done   (dly_done),
        .dly_start  (dly_start),
        .wdt_take   (wdt_take),
        .core_rst   (core_rst),
        .suspended  (suspended)
    );

    rcs_delay #(.SHORT_TICKS(SHORT_T), .LONG_TICKS(LONG_T)) u_dly (
        .clk     (clk),
        .rst_n   (pwr_good),
        .start   (dly_start),
        .long_sel(dly_long),
        .tick    (tick_us),
        .done    (dly_done)
    );

    rcs_status u_stat (
        .clk    (clk),
        .rst_n  (pwr_good),
        .set_usb(usb_bus_rst),
        .set_wdr(wdt_take),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .status (status)
    );

    // R7: no watchdog flag appears from a request made while in reset
    a_r7_wdt_ignored_in_reset: assert property (@(posedge clk) disable iff (!pwr_good)
        (core_rst && !status[FLAG_WDR]) |=> !status[FLAG_WDR]);
    // R8: bus reset leaves a running core running
    a_r8_bus_rst_no_core: assert property (@(posedge clk) disable iff (!pwr_good)
        (!core_rst && usb_bus_rst && !wdt_req) |=> !core_rst);
endmodule

// File: tb/sim_rst_cause_seq.sv
module sim_rst_cause_seq;
    localparam int unsigned SCALE = 32;
    localparam int unsigned SHORT = 128 / SCALE;
    localparam int unsigned LONG  = 96000 / SCALE;

    logic clk = 1'b0;
    logic pwr_good = 1'b0, tick_us = 1'b0, strap = 1'b0;
    logic usb_dm = 1'b1, usb_dp = 1'b0, usb_bus_rst = 1'b0, wdt_req = 1'b0;
    logic reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic core_rst, usb_addr_clr, suspended;
    logic [7:0] status;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    rst_cause_seq #(.SCALE(SCALE)) u0 (
        .clk(clk), .pwr_good(pwr_good), .tick_us(tick_us), .strap(strap),
        .usb_dm(usb_dm), .usb_dp(usb_dp), .usb_bus_rst(usb_bus_rst),
        .wdt_req(wdt_req), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .core_rst(core_rst), .usb_addr_clr(usb_addr_clr),
        .suspended(suspended), .status(status)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_us = 1'b1;
            @(negedge clk) tick_us = 1'b0;
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk) begin reg_we = 1'b1; reg_wdata = d; end
        @(negedge clk) reg_we = 1'b0;
    endtask

    task automatic power_cycle(input logic s, input logic dm, input logic dp);
        @(negedge clk) begin pwr_good = 1'b0; strap = s; usb_dm = dm; usb_dp = dp; end
        step(3);
        pwr_good = 1'b1;
        step(1);
    endtask

    task automatic t_reset_state;
        step(2);
        chk("R1 core_rst", {7'd0, core_rst}, 8'd1);
        chk("R1 usb_addr_clr", {7'd0, usb_addr_clr}, 8'd1);
        chk("R11 addr_clr in reset", {7'd0, usb_addr_clr}, 8'd1);
        chk("R1 suspended", {7'd0, suspended}, 8'd0);
        chk("R1 status", status, 8'h10);
    endtask

    task automatic t_long_delay;
        pwr_good = 1'b1;
        step(1);
        chk("R2 strap low no suspend", {7'd0, suspended}, 8'd0);
        step(20);
        chk("R5 no tick no release", {7'd0, core_rst}, 8'd1);
        ticks(SHORT);
        step(2);
        chk("R4 long when por set", {7'd0, core_rst}, 8'd1);
        ticks(LONG - SHORT - 1);
        step(2);
        chk("R5 one tick short", {7'd0, core_rst}, 8'd1);
        ticks(1);
        chk("R5 held at terminal", {7'd0, core_rst}, 8'd1);
        step(1);
        chk("R5 released", {7'd0, core_rst}, 8'd0);
        chk("R11 addr_clr off in run", {7'd0, usb_addr_clr}, 8'd0);
    endtask

    task automatic t_write_clear;
        wr(8'h00);
        chk("R9 por cleared", status, 8'h00);
        wr(8'hFF);
        chk("R9 write never sets", status, 8'h00);
    endtask

    task automatic t_bus_reset;
        @(negedge clk) usb_bus_rst = 1'b1;
        #1 chk("R8 addr_clr same cycle", {7'd0, usb_addr_clr}, 8'd1);
        @(negedge clk) usb_bus_rst = 1'b0;
        chk("R8 flag set", status, 8'h20);
        chk("R8 core still runs", {7'd0, core_rst}, 8'd0);
        @(negedge clk) begin usb_bus_rst = 1'b1; reg_we = 1'b1; reg_wdata = 8'h00; end
        @(negedge clk) begin usb_bus_rst = 1'b0; reg_we = 1'b0; end
        chk("R10 event beats write", status, 8'h20);
        wr(8'h10);
        chk("R9 selective clear", status, 8'h00);
    endtask

    task automatic t_watchdog;
        @(negedge clk) wdt_req = 1'b1;
        @(negedge clk) wdt_req = 1'b0;
        chk("R6 core reset", {7'd0, core_rst}, 8'd1);
        chk("R6 wdr flag", status, 8'h40);
        wr(8'h00);
        @(negedge clk) wdt_req = 1'b1;
        @(negedge clk) wdt_req = 1'b0;
        chk("R7 ignored in reset", status, 8'h00);
        ticks(SHORT - 1);
        step(2);
        chk("R4 short when por clear", {7'd0, core_rst}, 8'd1);
        ticks(1);
        step(1);
        chk("R7 no restart", {7'd0, core_rst}, 8'd0);
    endtask

    task automatic t_suspend_k;
        power_cycle(1'b1, 1'b1, 1'b0);
        chk("R2 suspended", {7'd0, suspended}, 8'd1);
        ticks(SHORT + 2);
        chk("R2 ticks ignored", {7'd0, core_rst}, 8'd1);
        @(negedge clk) usb_dp = 1'b1;
        step(5);
        chk("R3 SE1 no wake", {7'd0, suspended}, 8'd1);
        @(negedge clk) usb_dm = 1'b0;
        @(negedge clk) begin usb_dm = 1'b1; usb_dp = 1'b0; end
        chk("R3 K wakes", {7'd0, suspended}, 8'd0);
        ticks(SHORT);
        step(1);
        chk("R4 strap high short", {7'd0, core_rst}, 8'd0);
        chk("R1 por flag after power", status, 8'h10);
    endtask

    task automatic t_suspend_se0;
        power_cycle(1'b1, 1'b1, 1'b0);
        chk("R2 suspended again", {7'd0, suspended}, 8'd1);
        @(negedge clk) usb_dm = 1'b0;
        @(negedge clk) usb_dm = 1'b1;
        chk("R3 SE0 wakes", {7'd0, suspended}, 8'd0);
        power_cycle(1'b1, 1'b1, 1'b0);
        @(negedge clk) usb_bus_rst = 1'b1;
        @(negedge clk) usb_bus_rst = 1'b0;
        chk("R3 bus reset wakes", {7'd0, suspended}, 8'd0);
        chk("R8 flag in suspend", status, 8'h30);
        power_cycle(1'b1, 1'b1, 1'b1);
        chk("R2 non-idle lines skip suspend", {7'd0, suspended}, 8'd0);
        ticks(SHORT);
        step(1);
        chk("R4 strap high short direct", {7'd0, core_rst}, 8'd0);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_long_delay();
                t_write_clear();
                t_bus_reset();
                t_watchdog();
                t_suspend_k();
                t_suspend_se0();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule